// File: doc/BRIEF.md
# Per-Process Page Translation Unit

The unit turns a 32-bit virtual address into a physical address by reading one entry from a single-level page table in main memory. A request carries the virtual address, a write flag and a process number. The process number picks one of several table base registers. The unit adds four times the virtual page number to that base, reads the 32-bit entry over a request/grant memory port, and classifies the result. Each translation therefore costs exactly one table read before the data access that follows it.

The unit handles one translation at a time. It either returns the physical page from the entry joined to the unchanged 12-bit page offset, or it reports one of three faults: the entry is not valid, the page is not resident in DRAM, or a write targets a write-protected page. System software loads the table bases through a small write port while the unit is idle.

Top module: `page_xlate`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and every table base is 0, so the first fetch for any process reads address 4*VPN.
- R2: Each accepted request issues exactly one table read, at address base + 4*VPN, where VPN is `req_vaddr_i[31:12]`.
- R3: `req_pid_i` selects which of the 4 table bases is used, and a base write of value V for process P makes later fetches for P use V.
- R4: When no fault occurs, `fault_o` = 0 and `paddr_o` = {entry[19:0], `req_vaddr_i[11:0]`}.
- R5: When entry bit 31 (valid) is 0, `fault_o` = 1 whatever the other bits hold, and `paddr_o` = 0.
- R6: When bit 31 is 1 and bit 30 (resident) is 0, `fault_o` = 2 and `paddr_o` = 0. This applies even for a write with bit 29 set.
- R7: When bits 31 and 30 are 1, bit 29 (write-protect) is 1 and the request is a write, `fault_o` = 3 and `paddr_o` = 0. A read of the same entry completes with `fault_o` = 0.
- R8: `done_o` is a one-cycle pulse in the cycle after the read data arrives. `busy_o` is high from the cycle after acceptance through the `done_o` cycle, and low afterwards.
- R9: A request presented while `busy_o` is high is ignored: it causes no extra table read and no extra `done_o`.
- R10: A base write presented while `busy_o` is high is ignored. The base keeps its previous value.
- R11: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_gnt_i` is seen. Read data is expected exactly one cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, taken when idle |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_pid_i | input | 2 | Process number selecting the table base |
| busy_o | output | 1 | Translation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | 0 none, 1 invalid, 2 not resident, 3 write protected |
| paddr_o | output | 32 | Physical address, 0 on fault |
| base_we_i | input | 1 | Table base write strobe |
| base_pid_i | input | 2 | Process whose base is written |
| base_data_i | input | 32 | New table base byte address |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Table entry byte address |
| mem_gnt_i | input | 1 | Table memory accepts the request |
| mem_rvalid_i | input | 1 | Entry data valid, one cycle after grant |
| mem_rdata_i | input | 32 | Page table entry |

## Verification
A latched process number or page number that is wrong shows up on `mem_addr_o` in the first fetch cycle after acceptance, before any data returns. A wrong priority in the fault decode or a wrong offset latch shows up on `fault_o` and `paddr_o` with the `done_o` pulse, one cycle after the entry arrives. A state machine that fails to leave the busy states, or that re-arms on a request it should ignore, shows up either as a missing `done_o` or as an extra table read counted at the memory port. A base register that takes a write while busy only shows up at the next translation for that process, through its fetch address.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_ABSENT  = 2'd2,
    FLT_WPROT   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } state_e;
endpackage

// File: rtl/pt_base_regs.sv
module pt_base_regs #(
  parameter int N_PID  = 4,
  parameter int TBL_AW = 32,
  localparam int PID_W = $clog2(N_PID)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [PID_W-1:0]        wpid_i,
  input  logic [TBL_AW-1:0]       wdata_i,
  input  logic [PID_W-1:0]        rpid_i,
  output logic [TBL_AW-1:0]       rdata_o,
  output logic [N_PID*TBL_AW-1:0] bases_o
);
  logic [TBL_AW-1:0] base_q [N_PID];

  for (genvar g = 0; g < N_PID; g++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q[g] <= '0;
      else if (we_i && (wpid_i == PID_W'(g))) base_q[g] <= wdata_i;
    end
    assign bases_o[g*TBL_AW +: TBL_AW] = base_q[g];
  end

  assign rdata_o = base_q[rpid_i];
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check import pt_pkg::*; #(
  parameter int PTE_W = 32,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             write_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [1:0]       fault_o,
  output logic [PA_W-1:0]  paddr_o
);
  localparam int VALID_B = PTE_W - 1;
  localparam int RES_B   = PTE_W - 2;
  localparam int WP_B    = PTE_W - 3;

  fault_e fault;
  logic   unused_pte;
  assign unused_pte = ^pte_i[WP_B-1:PPN_W];

  // priority: invalid, then absent, then write protection
  always_comb begin
    if (!pte_i[VALID_B])             fault = FLT_INVALID;
    else if (!pte_i[RES_B])          fault = FLT_ABSENT;
    else if (write_i && pte_i[WP_B]) fault = FLT_WPROT;
    else                             fault = FLT_NONE;
  end

  assign fault_o = fault;
  assign paddr_o = {pte_i[PPN_W-1:0], offset_i};
endmodule

// File: rtl/page_xlate.sv
module page_xlate import pt_pkg::*; #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 20,
  parameter int N_PID  = 4,
  parameter int PTE_W  = 32,
  parameter int TBL_AW = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [VA_W-1:0]          req_vaddr_i,
  input  logic                     req_write_i,
  input  logic [$clog2(N_PID)-1:0] req_pid_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [1:0]               fault_o,
  output logic [PPN_W+OFF_W-1:0]   paddr_o,
  input  logic                     base_we_i,
  input  logic [$clog2(N_PID)-1:0] base_pid_i,
  input  logic [TBL_AW-1:0]        base_data_i,
  output logic                     mem_req_o,
  output logic [TBL_AW-1:0]        mem_addr_o,
  input  logic                     mem_gnt_i,
  input  logic                     mem_rvalid_i,
  input  logic [PTE_W-1:0]         mem_rdata_i
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PID_W  = $clog2(N_PID);
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int ENT_SH = $clog2(PTE_W / 8);

  state_e             state_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic               write_q;
  logic [PID_W-1:0]   pid_q;
  logic [1:0]         fault_q;
  logic [PA_W-1:0]    paddr_q;

  logic               base_we;
  logic [TBL_AW-1:0]  base_sel;
  logic [N_PID*TBL_AW-1:0] bases;
  logic [1:0]         chk_fault;
  logic [PA_W-1:0]    chk_paddr;

  assign base_we = base_we_i && (state_q == ST_IDLE);

  pt_base_regs #(.N_PID(N_PID), .TBL_AW(TBL_AW)) u_bases (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we),
    .wpid_i  (base_pid_i),
    .wdata_i (base_data_i),
    .rpid_i  (pid_q),
    .rdata_o (base_sel),
    .bases_o (bases)
  );

  pt_entry_check #(.PTE_W(PTE_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_check (
    .pte_i    (mem_rdata_i),
    .write_i  (write_q),
    .offset_i (off_q),
    .fault_o  (chk_fault),
    .paddr_o  (chk_paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      write_q <= 1'b0;
      pid_q   <= '0;
      fault_q <= '0;
      paddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vpn_q   <= req_vaddr_i[VA_W-1:OFF_W];
          off_q   <= req_vaddr_i[OFF_W-1:0];
          write_q <= req_write_i;
          pid_q   <= req_pid_i;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (mem_gnt_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          fault_q <= chk_fault;
          paddr_q <= (chk_fault == FLT_NONE) ? chk_paddr : '0;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_RESP);
  assign fault_o    = fault_q;
  assign paddr_o    = paddr_q;
  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = base_sel + (TBL_AW'(vpn_q) << ENT_SH);

  p_fetch_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_resp_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rvalid_i && busy_o && !mem_req_o && !done_o) |=> done_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_fault_zero_pa_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (fault_o != 2'd0)) |-> (paddr_o == '0));

  p_base_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(bases));
endmodule

// File: tb/tb_page_xlate.sv
`timescale 1ns/1ps
module tb_page_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_pid_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  fault_o;
  logic [31:0] paddr_o;
  logic        base_we_i = 1'b0;
  logic [1:0]  base_pid_i = '0;
  logic [31:0] base_data_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  page_xlate dut (.*);

  int n_chk = 0, n_fail = 0, n_reads = 0;
  logic [31:0] model_base [4];
  logic [31:0] pte_cur = '0;
  logic [31:0] exp_fetch = '0;
  bit          pend = 0;
  logic [31:0] pend_addr = '0;
  bit          finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [1:0] exp_fault(logic [31:0] pte, logic wr);
    if (!pte[31]) return 2'd1;
    if (!pte[30]) return 2'd2;
    if (wr && pte[29]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_pa(logic [31:0] pte, logic wr, logic [31:0] va);
    if (exp_fault(pte, wr) != 2'd0) return 32'h0;
    return {pte[19:0], va[11:0]};
  endfunction

  // table memory: grant at random, data one cycle after grant (R11)
  initial begin
    forever begin
      @(negedge clk_i);
      mem_rvalid_i = pend;
      mem_rdata_i  = pend ? pte_cur : 32'h0;
      if (pend) begin
        n_reads++;
        chk("R2 fetch address", pend_addr, exp_fetch);
      end
      mem_gnt_i = ($urandom % 3) != 0;
      pend      = mem_req_o && mem_gnt_i;
      pend_addr = mem_addr_o;
    end
  end

  task automatic write_base(logic [1:0] pid, logic [31:0] val);
    @(negedge clk_i);
    base_we_i = 1; base_pid_i = pid; base_data_i = val;
    @(negedge clk_i);
    base_we_i = 0;
    model_base[pid] = val;
  endtask

  // noise=1 drives a request and a base write while busy (R9, R10)
  task automatic xlate(logic [1:0] pid, logic [31:0] va, logic wr, logic [31:0] pte, bit noise);
    int reads0;
    bit got;
    pte_cur   = pte;
    exp_fetch = model_base[pid] + {10'd0, va[31:12], 2'b00};
    @(negedge clk_i);
    req_valid_i = 1; req_vaddr_i = va; req_write_i = wr; req_pid_i = pid;
    reads0 = n_reads;
    @(negedge clk_i);
    req_valid_i = 0;
    #1;
    chk("R8 busy after accept", {31'd0, busy_o}, 32'd1);
    if (noise) begin
      req_valid_i = 1; req_vaddr_i = ~va; req_pid_i = pid + 2'd1;
      base_we_i = 1; base_pid_i = pid; base_data_i = model_base[pid] ^ 32'h0001_0000;
    end
    got = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i); #1;
      if (mem_rvalid_i) begin got = 1; break; end
      chk("R8 no early done", {31'd0, done_o}, 32'd0);
    end
    if (!got) chk("R2 fetch issued", 32'd0, 32'd1);
    @(negedge clk_i); #1;
    req_valid_i = 0; base_we_i = 0;
    chk("R8 done pulse", {31'd0, done_o}, 32'd1);
    chk("R8 busy in done cycle", {31'd0, busy_o}, 32'd1);
    chk("R5/R6/R7 fault code", {30'd0, fault_o}, {30'd0, exp_fault(pte, wr)});
    chk("R4 physical address", paddr_o, exp_pa(pte, wr, va));
    @(negedge clk_i); #1;
    chk("R8 done cleared", {31'd0, done_o}, 32'd0);
    chk("R9 idle after done", {31'd0, busy_o}, 32'd0);
    chk("R9 single read", n_reads - reads0, 32'd1);
  endtask

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) model_base[i] = 32'h0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 busy reset", {31'd0, busy_o}, 32'd0);
    chk("R1 done reset", {31'd0, done_o}, 32'd0);
    rst_ni = 1;
    // R1: zero bases after reset
    xlate(2'd2, 32'h0004_5678, 0, 32'hC000_0123, 0);
    xlate(2'd1, 32'hFFFF_F000, 1, 32'hC00F_FFFF, 0);
    // R3: program distinct bases
    write_base(2'd0, 32'h1000_0000);
    write_base(2'd1, 32'h2000_4000);
    write_base(2'd2, 32'h3000_8000);
    write_base(2'd3, 32'h4000_C000);
    for (int p = 0; p < 4; p++)
      xlate(2'(p), 32'h0000_3ABC + (p << 12), 0, 32'hC000_0A00 + p, 0);
    // R5: invalid dominates other bits
    xlate(2'd0, 32'h1234_5678, 1, 32'h7FFF_FFFF, 0);
    xlate(2'd3, 32'h0000_0FFF, 0, 32'h0000_0000, 0);
    // R6: not resident dominates write protection
    xlate(2'd1, 32'h8000_0001, 1, 32'hA00A_BCDE, 0);
    xlate(2'd1, 32'h8000_0001, 0, 32'h800A_BCDE, 0);
    // R7: protected page, write faults, read completes
    xlate(2'd2, 32'hDEAD_BEEF, 1, 32'hE001_2345, 0);
    xlate(2'd2, 32'hDEAD_BEEF, 0, 32'hE001_2345, 0);
    xlate(2'd2, 32'hDEAD_BEEF, 1, 32'hC001_2345, 0);
    // R9/R10: request and base write while busy, then old base still used
    xlate(2'd3, 32'h0001_1000, 0, 32'hC000_0777, 1);
    xlate(2'd3, 32'h0001_1000, 0, 32'hC000_0777, 0);
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] pte, va;
      logic [1:0] pid;
      pid = 2'($urandom);
      va  = $urandom;
      pte = $urandom;
      if (($urandom % 4) != 0) pte[31] = 1;
      if (($urandom % 4) != 0) pte[30] = 1;
      if ((n % 37) == 0) write_base(2'($urandom), $urandom & 32'hFFFF_FFFC);
      xlate(pid, va, 1'($urandom), pte, (n % 11) == 0);
    end
    finish_run();
  end
endmodule